// File: doc/BRIEF.md
# Clocked-to-Asynchronous Static RAM Bridge

This block lets a clocked internal bus master reach an external asynchronous static RAM with a 19-bit address and a byte-wide bidirectional data bus. The master issues one request at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The bridge latches the address first, then drives the RAM's active-low select, write and output strobes. Every strobe is held for a whole number of clock cycles, and each count is derived at elaboration from the clock period and a speed-grade parameter by rounding the nanosecond minimums up to cycles.

The data bus is split into three signals, an output value, an output enable and an input value, so that a tri-state pad outside the block can be used. On a write, the bridge holds its data drive off for the first part of the write pulse. This leaves room for the RAM to release the bus, and the pulse is long enough to hold both that release time and the data overlap. A read is captured on the clock edge that ends the access wait, and it is returned with a one-cycle valid pulse. After a read, the bridge keeps all strobes idle for a turnaround period before it accepts more work. After a write, it adds recovery cycles as needed so that the full write-cycle minimum is met.

Speed grade encoding: 0 selects the fastest grade, 1 the middle grade and 2 the slowest. With the default 10 ns clock and grade 0, the cycle counts are as follows:
- read access: 6 cycles
- read turnaround: 2 cycles
- write pulse: 6 cycles
- bus-release delay inside the pulse: 3 cycles
- write recovery: 1 cycle

Top module: `sram_bridge`

## Requirements
- R1: After reset, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: sram_addr changes only in a cycle where sram_ce_n and sram_we_n are both 1, both before and after the change. While a strobe is low, sram_addr equals the address of the accepted request.
- R3: A read accepted at clock edge E0 drives sram_ce_n and sram_oe_n low from edge E1 for exactly RD_CYC cycles (6 by default), with sram_we_n held at 1. rsp_valid is 1 for exactly one cycle, after edge E1+RD_CYC. At that point rsp_rdata holds the value sram_dq_in carried on that edge.
- R4: A write accepted at E0 drives sram_ce_n and sram_we_n low from E1 for exactly WR_CYC cycles (6 by default), with sram_oe_n held at 1. The RAM stores the value on the data bus at the end of that overlap.
- R5: During a write, sram_dq_oe rises WHZ_CYC cycles after sram_we_n falls (3 by default) and falls on the same edge at which sram_we_n rises. This gives WR_CYC-WHZ_CYC cycles of driven data.
- R6: sram_dq_oe is never 1 while sram_ce_n and sram_oe_n are both 0. sram_dq_oe does not rise within TA_CYC cycles (2 by default) after the RAM's outputs were last enabled.
- R7: After a read, req_ready returns to 1 after edge E1+RD_CYC+TA_CYC (E9 by default). After a write, it returns after edge E1+WR_CYC+WREC_CYC (E8 by default), where WREC_CYC is at least 1.
- R8: req_ready is 0 from the accepting edge until the transaction ends. A request presented while req_ready is 0 is ignored and does not alter the memory.
- R9: Reads return the data last written to the same address, across patterns of all-zero, all-one and alternating bits, and at the highest address 19'h7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and accepting a request |
| req_addr | input | 19 | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Captured read data |
| sram_addr | output | 19 | RAM address lines |
| sram_ce_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 8 | Value for the data pads |
| sram_dq_oe | output | 1 | Enable of the data pad drivers |
| sram_dq_in | input | 8 | Value seen on the data pads |

## Verification
Every result is due a fixed number of edges after the accepting edge E0. The strobes change after E1. The data drive starts after E1+WHZ_CYC. The read pulse comes after E1+RD_CYC, and ready returns after E1+RD_CYC+TA_CYC or E1+WR_CYC+WREC_CYC. The bench indexes each cycle from E0 and samples one time unit after each rising edge, so every index is compared against counts it derives itself from the nanosecond minimums. A RAM model in the bench stores data only at the end of the select-and-write overlap. A monitor, sampled mid-cycle, counts address changes under active strobes, bus contention and early drive after an output release.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_RECOVER
    } seq_state_e;

    typedef enum logic [3:0] {
        T_ACCESS,
        T_OE_ACCESS,
        T_RELEASE,
        T_WE_PULSE,
        T_TO_END,
        T_WE_HIZ,
        T_DATA_OVL,
        T_WR_CYCLE
    } tparam_e;

    // Minimum (or maximum, for release times) in ns per grade 0/1/2.
    function automatic int grade_ns(tparam_e kind, int grade);
        int g;
        g = (grade < 0) ? 0 : (grade > 2) ? 2 : grade;
        case (kind)
            T_ACCESS:    return (g == 0) ? 55 : (g == 1) ? 70 : 100;
            T_OE_ACCESS: return (g == 0) ? 30 : (g == 1) ? 35 : 50;
            T_RELEASE:   return (g == 0) ? 20 : (g == 1) ? 25 : 30;
            T_WE_PULSE:  return (g == 0) ? 45 : (g == 1) ? 55 : 70;
            T_TO_END:    return (g == 0) ? 50 : (g == 1) ? 60 : 80;
            T_WE_HIZ:    return (g == 2) ? 40 : 30;
            T_DATA_OVL:  return (g == 0) ? 25 : (g == 1) ? 30 : 40;
            T_WR_CYCLE:  return (g == 0) ? 55 : (g == 1) ? 70 : 100;
            default:     return 0;
        endcase
    endfunction

    function automatic int ceil_cycles(int ns, int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
    import sram_bridge_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce,
    output logic              mem_we,
    output logic              mem_oe,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int RD_CYC   = imax(ceil_cycles(grade_ns(T_ACCESS, SPEED_GRADE), CLK_PERIOD_NS),
                                   ceil_cycles(grade_ns(T_OE_ACCESS, SPEED_GRADE), CLK_PERIOD_NS));
    localparam int TA_CYC   = imax(1, ceil_cycles(grade_ns(T_RELEASE, SPEED_GRADE), CLK_PERIOD_NS));
    localparam int WHZ_CYC  = imax(1, ceil_cycles(grade_ns(T_WE_HIZ, SPEED_GRADE), CLK_PERIOD_NS));
    localparam int DW_CYC   = imax(1, ceil_cycles(grade_ns(T_DATA_OVL, SPEED_GRADE), CLK_PERIOD_NS));
    localparam int WR_CYC   = imax(imax(ceil_cycles(grade_ns(T_WE_PULSE, SPEED_GRADE), CLK_PERIOD_NS),
                                        ceil_cycles(grade_ns(T_TO_END, SPEED_GRADE), CLK_PERIOD_NS)),
                                   WHZ_CYC + DW_CYC);
    localparam int WC_CYC   = ceil_cycles(grade_ns(T_WR_CYCLE, SPEED_GRADE), CLK_PERIOD_NS);
    localparam int WREC_CYC = imax(1, WC_CYC - 1 - WR_CYC);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WR_CYC), imax(TA_CYC, WREC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LAST   = CNT_W'(TA_CYC - 1);
    localparam logic [CNT_W-1:0] WREC_LAST = CNT_W'(WREC_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_FROM  = CNT_W'(WHZ_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ce;
        logic              we;
        logic              oe;
        logic              doe;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      rec_done;

    assign rec_done = (r_q.cnt == (r_q.is_wr ? WREC_LAST : TA_LAST));

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_SETUP;
                    r_d.addr  = req_addr;
                    r_d.is_wr = req_write;
                    r_d.wdata = req_wdata;
                end
            end
            ST_SETUP: begin
                r_d.state = r_q.is_wr ? ST_WRITE : ST_READ;
                r_d.cnt   = '0;
                r_d.ce    = 1'b1;
                r_d.we    = r_q.is_wr;
                r_d.oe    = !r_q.is_wr;
                r_d.doe   = 1'b0;
            end
            ST_READ: begin
                if (r_q.cnt == RD_LAST) begin
                    r_d.state  = ST_RECOVER;
                    r_d.cnt    = '0;
                    r_d.rdata  = mem_din;
                    r_d.rvalid = 1'b1;
                    r_d.ce     = 1'b0;
                    r_d.oe     = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WRITE: begin
                if (r_q.cnt == WR_LAST) begin
                    r_d.state = ST_RECOVER;
                    r_d.cnt   = '0;
                    r_d.ce    = 1'b0;
                    r_d.we    = 1'b0;
                    r_d.doe   = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    r_d.doe = (r_q.cnt >= DRV_FROM);
                end
            end
            ST_RECOVER: begin
                if (rec_done) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_rdata = r_q.rdata;
    assign mem_addr  = r_q.addr;
    assign mem_ce    = r_q.ce;
    assign mem_we    = r_q.we;
    assign mem_oe    = r_q.oe;
    assign mem_dout  = r_q.wdata;
    assign mem_doe   = r_q.doe;

    // R2: address moves only with both select and write strobes idle
    a_r2_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (!mem_ce && !mem_we && !$past(mem_ce) && !$past(mem_we)));

    // R4: write strobe only inside an active select with outputs disabled
    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_ce && !mem_oe));

    // R5: data drive only while the write strobe is active
    a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> mem_we);

    // R5: drive starts only after the strobe has already been active a cycle
    a_r5_drive_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_doe) |-> $past(mem_we));

    // R6: no drive while the RAM outputs are enabled
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> !(mem_ce && mem_oe));

    // R3: read data pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: acceptance closes the handshake for the next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_bridge_pads.sv
module sram_bridge_pads #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ce,
    input  logic              mem_we,
    input  logic              mem_oe,
    input  logic [DATA_W-1:0] mem_dout,
    input  logic              mem_doe,
    output logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] pad_addr,
    output logic              pad_ce_n,
    output logic              pad_we_n,
    output logic              pad_oe_n,
    output logic [DATA_W-1:0] pad_dq_out,
    output logic              pad_dq_oe,
    input  logic [DATA_W-1:0] pad_dq_in
);

    // Internal strobes are active high; the RAM pins are active low.
    assign pad_addr   = mem_addr;
    assign pad_ce_n   = ~mem_ce;
    assign pad_we_n   = ~mem_we;
    assign pad_oe_n   = ~mem_oe;
    assign pad_dq_out = mem_dout;
    assign pad_dq_oe  = mem_doe;
    assign mem_din    = pad_dq_in;

    // R1: inverted strobes never show a write without a select
    always_comb begin
        a_r1_pin_polarity: assert (pad_we_n || !pad_ce_n || !mem_we);
    end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge #(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    logic [ADDR_W-1:0] m_addr;
    logic              m_ce, m_we, m_oe, m_doe;
    logic [DATA_W-1:0] m_dout, m_din;

    sram_bridge_seq #(
        .CLK_PERIOD_NS(CLK_PERIOD_NS),
        .SPEED_GRADE  (SPEED_GRADE),
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .mem_addr (m_addr),
        .mem_ce   (m_ce),
        .mem_we   (m_we),
        .mem_oe   (m_oe),
        .mem_dout (m_dout),
        .mem_doe  (m_doe),
        .mem_din  (m_din)
    );

    sram_bridge_pads #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pads (
        .mem_addr  (m_addr),
        .mem_ce    (m_ce),
        .mem_we    (m_we),
        .mem_oe    (m_oe),
        .mem_dout  (m_dout),
        .mem_doe   (m_doe),
        .mem_din   (m_din),
        .pad_addr  (sram_addr),
        .pad_ce_n  (sram_ce_n),
        .pad_we_n  (sram_we_n),
        .pad_oe_n  (sram_oe_n),
        .pad_dq_out(sram_dq_out),
        .pad_dq_oe (sram_dq_oe),
        .pad_dq_in (sram_dq_in)
    );

endmodule

// File: tb/tb_sram_bridge.sv
`timescale 1ns/1ps
module tb_sram_bridge;

    localparam int PER = 10;
    function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
    function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction
    // grade 0 minimums, converted independently of the design
    localparam int E_RD   = mx(cdiv(55, PER), cdiv(30, PER));
    localparam int E_TA   = mx(1, cdiv(20, PER));
    localparam int E_WHZ  = cdiv(30, PER);
    localparam int E_WR   = mx(mx(cdiv(45, PER), cdiv(50, PER)), cdiv(30, PER) + cdiv(25, PER));
    localparam int E_WREC = mx(1, cdiv(55, PER) - 1 - E_WR);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    logic [7:0]  sram_dq_out;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_in;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    sram_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // RAM model: 256 bytes on the low address bits
    logic [7:0] mem [256];
    logic       ram_drv;
    assign ram_drv    = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq_in = sram_dq_oe ? sram_dq_out : (ram_drv ? mem[sram_addr[7:0]] : 8'hA5);

    int v_addr = 0, v_cont = 0, v_early = 0;

    initial begin
        logic        pw, pce, pwe;
        logic [18:0] pa;
        logic [7:0]  ld;
        int          since;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        pw = 0; pce = 1; pwe = 1; pa = '0; ld = '0; since = 100;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                if (sram_addr != pa && (!pce || !pwe || !sram_ce_n || !sram_we_n)) v_addr++;
                if (sram_dq_oe && ram_drv) v_cont++;
                if (sram_dq_oe && since < E_TA) v_early++;
                if (!sram_ce_n && !sram_we_n) ld = sram_dq_oe ? sram_dq_out : 8'hXX;
                if (pw && !(!sram_ce_n && !sram_we_n)) mem[pa[7:0]] = ld;
            end
            since = ram_drv ? 0 : since + 1;
            pw  = !sram_ce_n && !sram_we_n;
            pce = sram_ce_n; pwe = sram_we_n; pa = sram_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes idle", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        chk(!sram_dq_oe && !rsp_valid, "R1 no drive, no valid", {sram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
    endtask

    // inject: present a second write to iaddr while busy
    task automatic do_write(input logic [18:0] a, input logic [7:0] d,
                            input bit inject, input logic [18:0] iaddr);
        int wf = -1, wc = 0, wl = -1, df = -1, dc = 0, dl = -1, rdy = -1;
        bit oe_low = 0, addr_bad = 0;
        chk(req_ready, "R8 ready before write", req_ready, 1);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0;
        for (int i = 0; i < 20; i++) begin
            if (i == 0) chk(!req_ready, "R8 busy after accept", req_ready, 0);
            if (inject && i == 2) begin
                req_valid = 1; req_write = 1; req_addr = iaddr; req_wdata = 8'hEE;
            end
            if (inject && i == 3) req_valid = 0;
            if (!sram_we_n) begin if (wf < 0) wf = i; wc++; wl = i; end
            if (sram_dq_oe) begin if (df < 0) df = i; dc++; dl = i; end
            if (!sram_oe_n) oe_low = 1;
            if (!sram_ce_n && sram_addr != a) addr_bad = 1;
            if (i > 0 && req_ready) begin rdy = i; break; end
            @(posedge clk); #1;
        end
        chk(wf == 1 && wc == E_WR, "R4 write pulse start/width", wf * 100 + wc, 100 + E_WR);
        chk(!oe_low, "R4 output enable idle in write", oe_low, 0);
        chk(df == 1 + E_WHZ && dc == E_WR - E_WHZ, "R5 drive start/width", df * 100 + dc,
            (1 + E_WHZ) * 100 + E_WR - E_WHZ);
        chk(dl == wl, "R5 drive ends with pulse", dl, wl);
        chk(!addr_bad, "R2 address under strobe", addr_bad, 0);
        chk(rdy == 1 + E_WR + E_WREC, "R7 write ready index", rdy, 1 + E_WR + E_WREC);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
        int of = -1, oc = 0, vi = -1, vc = 0, rdy = -1;
        bit we_low = 0;
        logic [7:0] got = '0;
        chk(req_ready, "R8 ready before read", req_ready, 1);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 8'h00;
        @(posedge clk); #1;
        req_valid = 0;
        for (int i = 0; i < 20; i++) begin
            if (!sram_oe_n && !sram_ce_n) begin if (of < 0) of = i; oc++; end
            if (!sram_we_n) we_low = 1;
            if (rsp_valid) begin if (vi < 0) begin vi = i; got = rsp_rdata; end vc++; end
            if (i > 0 && req_ready) begin rdy = i; break; end
            @(posedge clk); #1;
        end
        chk(of == 1 && oc == E_RD && !we_low, "R3 read strobes", of * 100 + oc, 100 + E_RD);
        chk(vi == 1 + E_RD && vc == 1, "R3 valid index/pulse", vi * 100 + vc, (1 + E_RD) * 100 + 1);
        chk(got == exp, "R9 read data", got, exp);
        chk(rdy == 1 + E_RD + E_TA, "R7 read ready index", rdy, 1 + E_RD + E_TA);
    endtask

    initial begin
        #(200000 * PER);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        rst_n = 1;
        @(posedge clk); #1;
        test_reset();

        do_write(19'h00012, 8'h5A, 0, '0);
        do_read (19'h00012, 8'h5A);
        do_write(19'h7FFFF, 8'hFF, 0, '0);
        do_write(19'h00055, 8'h00, 0, '0);
        do_write(19'h00034, 8'hA5, 0, '0);
        do_read (19'h7FFFF, 8'hFF);
        do_read (19'h00055, 8'h00);
        do_read (19'h00034, 8'hA5);
        do_read (19'h00099, 8'h00);

        // R8: request while busy must be ignored
        do_write(19'h00022, 8'h3C, 0, '0);
        do_write(19'h00011, 8'h77, 1, 19'h00022);
        repeat (4) begin
            chk(sram_ce_n && req_ready, "R8 no extra transaction", {sram_ce_n, req_ready}, 3);
            @(posedge clk); #1;
        end
        do_read (19'h00022, 8'h3C);
        do_read (19'h00011, 8'h77);

        chk(v_addr == 0, "R2 address change under strobe", v_addr, 0);
        chk(v_cont == 0, "R6 bus contention", v_cont, 0);
        chk(v_early == 0, "R6 drive inside release window", v_early, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule